// File: doc/BRIEF.md
# Bus Write Error Capture Logger

This block sits beside the point where a memory-mapped interconnect serializes its writes. It watches two channels. The first is the write-address handshake. The second is the write-response handshake. When a write completes with an error response, the block keeps one record of it. An error response includes a store aimed at a read-only register. Such an event counts as uncorrectable. The record holds the full 40-bit target address, the 9-bit requester ID and the 2-bit response code, and it stays until software clears it.

A small table indexed by requester ID keeps the address of the most recent accepted write for each ID. That address is picked up when the matching response arrives. Software reads the record through two 32-bit words on a simple register port. Writing zero to the word at offset 0x0 empties the record and re-arms capture. A level interrupt, gated by an enable input, is available for systems that need fast handling. Other systems can poll the valid flag instead.

Top module: `wr_err_logger`

## Requirements
- R1: While reset is held, and just after it, both log words read 0x00000000 and `irq` is low.
- R2: A write-response handshake (`b_valid` and `b_ready` both high) whose code has bit 1 set captures the event. SLVERR is 2'b10 and DECERR is 2'b11. Bit 31 of the word at offset 0x0 reads 1 from the cycle after that clock edge.
- R3: A response with code OKAY (2'b00) or EXOKAY (2'b01) never captures. An error code shown with `b_ready` low also never captures.
- R4: The word at offset 0x0 is laid out as follows. Bit 31 is the valid flag. Bits 18:17 hold the response code. Bits 16:8 hold the requester ID. Bits 7:0 hold address bits 39:32. All other bits read 0.
- R5: The word at offset 0x4 holds address bits 31:0. The captured address is the one from the latest accepted write-address handshake (`aw_valid` and `aw_ready`) with the same ID as the response. This holds even while writes with other IDs are outstanding.
- R6: While the valid flag is set, later error responses change neither word. The first error is kept.
- R7: A register write of 0x00000000 to offset 0x0 sets both words to zero from the next cycle. A register write of a nonzero value to offset 0x0 has no effect. Any write to offset 0x4 also has no effect.
- R8: If a clearing write and an error response happen in the same cycle, the new error is captured.
- R9: `irq` is high exactly when the valid flag is set and `irq_en` is high.
- R10: Register reads are combinational from `reg_addr`. Offsets other than 0x0 and 0x4 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aw_valid | input | 1 | Write-address valid seen on the interconnect |
| aw_ready | input | 1 | Write-address ready seen on the interconnect |
| aw_id | input | 9 | Requester ID of the write address |
| aw_addr | input | 40 | Target address of the write |
| b_valid | input | 1 | Write-response valid |
| b_ready | input | 1 | Write-response ready |
| b_id | input | 9 | Requester ID of the response |
| b_resp | input | 2 | Response code |
| reg_addr | input | 3 | Register byte offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Level interrupt |

## Verification
A capture caused by a response handshake is visible on the register port one cycle after the clock edge that samples the handshake. The same delay applies to a clear. An address stored at a write-address edge is available to a response one cycle later. Reads and `irq` follow register state with no further delay, so `irq` also reacts in that same cycle when only `irq_en` changes. The bench steps its reference model on the same edge as the design and compares `irq` and the addressed word one nanosecond after every rising edge. Each directed check samples after the falling edge that follows its stimulus.

// File: rtl/wel_pkg.sv
package wel_pkg;
  localparam int ID_W    = 9;
  localparam int ADDR_W  = 40;
  localparam int RESP_W  = 2;
  localparam int WORD_W  = 32;
  localparam int HI_W    = ADDR_W - WORD_W;
  localparam int TAB_DEPTH = 1 << ID_W;

  typedef logic [ID_W-1:0]   rid_t;
  typedef logic [ADDR_W-1:0] waddr_t;
  typedef logic [RESP_W-1:0] resp_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [RESP_W-1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } bresp_e;

  typedef struct packed {
    logic   valid;
    resp_t  code;
    rid_t   rid;
    waddr_t addr;
  } log_rec_t;

  function automatic logic resp_is_error(resp_t r);
    return r[1];
  endfunction

  function automatic word_t pack_upper(log_rec_t rec);
    word_t w;
    w = '0;
    w[31]    = rec.valid;
    w[18:17] = rec.code;
    w[16:8]  = rec.rid;
    w[7:0]   = rec.addr[ADDR_W-1:WORD_W];
    return w;
  endfunction

  function automatic word_t pack_lower(log_rec_t rec);
    return rec.addr[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/wel_addr_table.sv
module wel_addr_table
  import wel_pkg::*;
#(
  parameter int DEPTH = TAB_DEPTH
) (
  input  logic   clk,
  input  logic   wr_en,
  input  rid_t   wr_id,
  input  waddr_t wr_addr,
  input  rid_t   rd_id,
  output waddr_t rd_addr
);
  waddr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_id] <= wr_addr;
  end

  assign rd_addr = mem[rd_id];
endmodule

// File: rtl/wel_capture.sv
module wel_capture
  import wel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rsp_hs,
  input  resp_t    rsp_code,
  input  rid_t     rsp_id,
  input  waddr_t   rsp_addr,
  input  logic     clr_req,
  output logic     cap_fire,
  output log_rec_t rec
);
  logic armed;

  assign armed    = !rec.valid || clr_req;
  assign cap_fire = rsp_hs && resp_is_error(rsp_code) && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec <= '0;
    end else if (cap_fire) begin
      rec.valid <= 1'b1;
      rec.code  <= rsp_code;
      rec.rid   <= rsp_id;
      rec.addr  <= rsp_addr;
    end else if (clr_req) begin
      rec <= '0;
    end
  end
endmodule

// File: rtl/wel_regport.sv
module wel_regport
  import wel_pkg::*;
#(
  parameter int          REG_AW    = 3,
  parameter logic [REG_AW-1:0] UPPER_OFF = 3'h0,
  parameter logic [REG_AW-1:0] LOWER_OFF = 3'h4
) (
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  word_t             reg_wdata,
  input  log_rec_t          rec,
  output logic              clr_req,
  output word_t             upper_word,
  output word_t             lower_word,
  output word_t             reg_rdata
);
  assign upper_word = pack_upper(rec);
  assign lower_word = pack_lower(rec);
  assign clr_req    = reg_wr_en && (reg_addr == UPPER_OFF) && (reg_wdata == '0);

  always_comb begin
    if (reg_addr == UPPER_OFF)      reg_rdata = upper_word;
    else if (reg_addr == LOWER_OFF) reg_rdata = lower_word;
    else                            reg_rdata = '0;
  end
endmodule

// File: rtl/wr_err_logger.sv
module wr_err_logger
  import wel_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [8:0]        aw_id,
  input  logic [39:0]       aw_addr,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic [8:0]        b_id,
  input  logic [1:0]        b_resp,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              irq_en,
  output logic              irq
);
  localparam logic [REG_AW-1:0] UPPER_OFF = REG_AW'(0);
  localparam logic [REG_AW-1:0] LOWER_OFF = REG_AW'(WORD_W / 8);

  logic     aw_hs;
  logic     b_hs;
  waddr_t   b_addr;
  logic     cap_fire;
  logic     clr_fire;
  log_rec_t rec;
  logic     log_valid;
  word_t    upper_word;
  word_t    lower_word;

  assign aw_hs = aw_valid && aw_ready;
  assign b_hs  = b_valid && b_ready;

  wel_addr_table #(.DEPTH(TAB_DEPTH)) u_tab (
    .clk     (clk),
    .wr_en   (aw_hs),
    .wr_id   (aw_id),
    .wr_addr (aw_addr),
    .rd_id   (b_id),
    .rd_addr (b_addr)
  );

  wel_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsp_hs   (b_hs),
    .rsp_code (b_resp),
    .rsp_id   (b_id),
    .rsp_addr (b_addr),
    .clr_req  (clr_fire),
    .cap_fire (cap_fire),
    .rec      (rec)
  );

  wel_regport #(
    .REG_AW    (REG_AW),
    .UPPER_OFF (UPPER_OFF),
    .LOWER_OFF (LOWER_OFF)
  ) u_regs (
    .reg_addr   (reg_addr),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .rec        (rec),
    .clr_req    (clr_fire),
    .upper_word (upper_word),
    .lower_word (lower_word),
    .reg_rdata  (reg_rdata)
  );

  assign log_valid = rec.valid;
  assign irq       = log_valid && irq_en;
endmodule

// File: rtl/wel_checker.sv
module wel_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        b_valid,
  input logic        b_ready,
  input logic [1:0]  b_resp,
  input logic        irq_en,
  input logic        irq,
  input logic        log_valid,
  input logic        cap_fire,
  input logic        clr_fire,
  input logic [31:0] upper_word,
  input logic [31:0] lower_word
);
  p_capture_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (log_valid && upper_word[31]));

  p_valid_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_valid) |-> $past(cap_fire));

  p_okay_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_ready && !b_resp[1] && !log_valid) |=> !log_valid);

  p_no_ready_no_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_ready) |-> !cap_fire);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid && !clr_fire) |=> ($stable(upper_word) && $stable(lower_word)));

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && !cap_fire) |=> (upper_word == 32'h0 && lower_word == 32'h0));

  p_clear_and_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && cap_fire) |=> log_valid);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $stable(irq_en)) |-> $past(cap_fire));
endmodule

bind wr_err_logger wel_checker u_wel_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .b_valid    (b_valid),
  .b_ready    (b_ready),
  .b_resp     (b_resp),
  .irq_en     (irq_en),
  .irq        (irq),
  .log_valid  (log_valid),
  .cap_fire   (cap_fire),
  .clr_fire   (clr_fire),
  .upper_word (upper_word),
  .lower_word (lower_word)
);

// File: tb/wr_err_logger_bench.sv
`timescale 1ns/100ps
module wr_err_logger_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aw_valid = 1'b0, aw_ready = 1'b0;
  logic [8:0]  aw_id = '0;
  logic [39:0] aw_addr = '0;
  logic        b_valid = 1'b0, b_ready = 1'b0;
  logic [8:0]  b_id = '0;
  logic [1:0]  b_resp = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_en = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wr_err_logger u_wr_err_logger (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq)
  );

  // Behavioural reference model
  longint unsigned tab [int];
  bit              m_valid = 0;
  int unsigned     m_resp = 0, m_id = 0;
  longint unsigned m_addr = 0;

  function automatic longint unsigned model_word(int unsigned off);
    longint unsigned w;
    if (off == 0) begin
      w = (longint'(m_valid) << 31) | (longint'(m_resp) << 17) |
          (longint'(m_id) << 8) | (m_addr >> 32);
      return w;
    end
    if (off == 4) return m_addr & 64'hFFFF_FFFF;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0; m_resp <= 0; m_id <= 0; m_addr <= 0;
    end else begin
      bit clr, err;
      longint unsigned looked;
      clr = reg_wr_en && reg_addr == 0 && reg_wdata == 0;
      err = b_valid && b_ready && (b_resp == 2 || b_resp == 3);
      looked = tab.exists(int'(b_id)) ? tab[int'(b_id)] : 0;
      if (err && (!m_valid || clr)) begin
        m_valid <= 1; m_resp <= b_resp; m_id <= b_id; m_addr <= looked;
      end else if (clr) begin
        m_valid <= 0; m_resp <= 0; m_id <= 0; m_addr <= 0;
      end
      if (aw_valid && aw_ready) tab[int'(aw_id)] = aw_addr;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R9 interrupt, R10 read data)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R9 cycle irq", {31'b0, irq}, {31'b0, m_valid && irq_en});
      check("R10 cycle rdata", reg_rdata, 32'(model_word(reg_addr)));
    end
  end

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic send_aw(input logic [8:0] id, input logic [39:0] a);
    aw_valid = 1; aw_ready = 1; aw_id = id; aw_addr = a;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
  endtask

  task automatic send_b(input logic [8:0] id, input logic [1:0] r, input logic rdy);
    b_valid = 1; b_ready = rdy; b_id = id; b_resp = r;
    @(negedge clk);
    b_valid = 0; b_ready = 0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0; reg_wdata = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(3'h0, v); check("R1 upper in reset", v, 32'h0);
    rd(3'h4, v); check("R1 lower in reset", v, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    irq_en = 1;
    @(negedge clk);
    rd(3'h0, v); check("R1 upper after reset", v, 32'h0);

    send_aw(9'd5, 40'hA5_1234_5678);
    send_b(9'd5, 2'b00, 1'b1);
    rd(3'h0, v); check("R3 OKAY ignored", v, 32'h0);
    send_b(9'd5, 2'b01, 1'b1);
    rd(3'h0, v); check("R3 EXOKAY ignored", v, 32'h0);
    send_b(9'd5, 2'b10, 1'b0);
    rd(3'h0, v); check("R3 no ready ignored", v, 32'h0);

    send_b(9'd5, 2'b10, 1'b1);
    rd(3'h0, v); check("R2 R4 SLVERR upper", v, 32'h8004_05A5);
    rd(3'h4, v); check("R5 lower address", v, 32'h1234_5678);
    check("R9 irq set", {31'b0, irq}, 32'h1);

    send_aw(9'd7, 40'h11_2222_3333);
    send_b(9'd7, 2'b11, 1'b1);
    rd(3'h0, v); check("R6 sticky upper", v, 32'h8004_05A5);
    rd(3'h4, v); check("R6 sticky lower", v, 32'h1234_5678);

    irq_en = 0; #1;
    check("R9 irq gated", {31'b0, irq}, 32'h0);
    irq_en = 1;

    reg_write(3'h0, 32'h0000_0001);
    rd(3'h0, v); check("R7 nonzero write ignored", v, 32'h8004_05A5);
    reg_write(3'h4, 32'h0);
    rd(3'h4, v); check("R7 lower write ignored", v, 32'h1234_5678);
    reg_write(3'h0, 32'h0);
    rd(3'h0, v); check("R7 cleared upper", v, 32'h0);
    rd(3'h4, v); check("R7 cleared lower", v, 32'h0);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);

    send_aw(9'd3, 40'h01_AAAA_0000);
    send_aw(9'd9, 40'h3C_DEAD_BEEF);
    send_b(9'd3, 2'b00, 1'b1);
    send_b(9'd9, 2'b11, 1'b1);
    rd(3'h0, v); check("R5 DECERR by id upper", v, 32'h8006_093C);
    rd(3'h4, v); check("R5 DECERR by id lower", v, 32'hDEAD_BEEF);

    send_aw(9'h1FF, 40'hFF_0000_0001);
    reg_wr_en = 1; reg_addr = 3'h0; reg_wdata = 32'h0;
    b_valid = 1; b_ready = 1; b_id = 9'h1FF; b_resp = 2'b10;
    @(negedge clk);
    reg_wr_en = 0; b_valid = 0; b_ready = 0;
    rd(3'h0, v); check("R8 clear with error upper", v, 32'h8005_FFFF);
    rd(3'h4, v); check("R8 clear with error lower", v, 32'h0000_0001);

    rd(3'h2, v); check("R10 offset 2 reads zero", v, 32'h0);
    rd(3'h6, v); check("R10 offset 6 reads zero", v, 32'h0);

    rst_n = 0; #1;
    rd(3'h0, v); check("R1 reset clears log", v, 32'h0);
    check("R1 reset clears irq", {31'b0, irq}, 32'h0);

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule